// File: doc/BRIEF.md
# S/PDIF Sample Word Formatter

This block sits between a transmit word queue and an S/PDIF subframe serializer. Each time the serializer asks for a subframe, the block pulls a 32-bit word over a valid/ready port. It unpacks that word into a 24-bit audio field, the four per-subframe flag bits (validity, user, channel status, parity) and a 4-bit preamble code. The word layout depends on a 2-bit format select and a pack enable. Three formats carry right-justified PCM of 16, 20 or 24 bits. A raw format carries the flags and the preamble inside the word itself. A packed format holds a left and a right 16-bit sample in one word.

The serializer raises `sf_req` for one cycle per subframe. In that same cycle the block raises `word_ready` if the subframe needs a new word. The source may keep `word_valid` high for as long as it likes: a word is taken only in a cycle where `word_valid` and `word_ready` are both high. A source that is not ready is not stalled. The block emits an underrun subframe in that slot and does not wait for the word. The formatted fields appear in registers one cycle after the request and are marked by `sf_valid`. A missed word sets a sticky `underrun` flag, which stays high until `err_clr` is raised.

Top module: `spdif_word_fmt`

## Requirements
- R1: Format 2'b00 without pack: word bits 15:0 go to audio bits 23:8, audio bits 7:0 are zero, and all four flags and the preamble code are zero.
- R2: Format 2'b01: word bits 19:0 go to audio bits 23:4, audio bits 3:0 are zero, and flags and preamble are zero.
- R3: Format 2'b10: word bits 23:0 go to audio bits 23:0, and flags and preamble are zero.
- R4: Format 2'b11 (raw): P is word bit 31, C is bit 30, U is bit 29 and V is bit 28. Audio bits 23:4 take word bits 27:8, audio bits 3:0 take the auxiliary bits 7:4, and the preamble code is word bits 3:0.
- R5: Format 2'b00 with `pack_en` set (packed): a taken word first gives a left subframe from bits 15:0. The next request gives a right subframe from bits 31:16, with audio bits 7:0 zero. `word_ready` stays low on the right subframe.
- R6: `pack_en` has no effect when the format select is not 2'b00. In that case, and whenever packing is off, a right half still held back is discarded.
- R7: `word_ready` is high only in a cycle where `sf_req` is high and a new word is needed. Without a request, the output fields hold their values.
- R8: The output fields update, and `sf_valid` pulses for one cycle, in the cycle after a cycle with `sf_req` high.
- R9: A request that needs a word while `word_valid` is low gives audio zero, V=1, U=C=P=0 and preamble 0. It consumes nothing, sets `underrun`, and leaves no packed right half pending.
- R10: `underrun` stays set until `err_clr` is high in a cycle without a new underrun. If both happen in the same cycle, the new underrun wins.
- R11: After reset, `sf_valid`, `underrun`, all output fields and the pending packed half are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_data | input | 32 | Word from the transmit queue |
| word_valid | input | 1 | Word present |
| word_ready | output | 1 | Word taken this cycle when valid is high |
| fmt_mode | input | 2 | 00 16-bit, 01 20-bit, 10 24-bit, 11 raw |
| pack_en | input | 1 | Two 16-bit samples per word (format 00 only) |
| sf_req | input | 1 | Serializer asks for the next subframe |
| err_clr | input | 1 | Clears the sticky underrun flag |
| sf_valid | output | 1 | Fields updated this cycle |
| sf_audio | output | 24 | Audio field, MSB aligned |
| sf_v | output | 1 | Validity flag |
| sf_u | output | 1 | User data bit |
| sf_c | output | 1 | Channel status bit |
| sf_p | output | 1 | Parity bit |
| sf_preamble | output | 4 | Preamble code (raw format only, else 0) |
| underrun | output | 1 | Sticky: a word was missing when needed |

## Verification
Directed words with distinct patterns in every nibble are sent in each format. Any slice taken from the wrong bit position, or aligned to the wrong end, shows up as a wrong nibble. Packed sequences check that left comes before right and that no word is taken for the right half. They are mixed with mode changes in the middle of a pair, which check that the held half is discarded. A long random run changes format, pack, request gaps and source stalls every cycle. It tells hold-without-request apart from update, and starvation apart from normal data.

// File: rtl/spdif_fmt_pkg.sv
package spdif_fmt_pkg;
  localparam int WORD_W  = 32;
  localparam int AUDIO_W = 24;
  localparam int HALF_W  = WORD_W / 2;
  localparam int PRE_W   = 4;
  localparam int AUX_W   = 4;
  localparam int RAW_W   = AUDIO_W - AUX_W;

  typedef enum logic [1:0] {
    FMT_16  = 2'b00,
    FMT_20  = 2'b01,
    FMT_24  = 2'b10,
    FMT_RAW = 2'b11
  } fmt_mode_e;

  typedef struct packed {
    logic [AUDIO_W-1:0] audio;
    logic               v;
    logic               u;
    logic               c;
    logic               p;
    logic [PRE_W-1:0]   pre;
  } subframe_t;
endpackage

// File: rtl/spdif_fmt_unpack.sv
module spdif_fmt_unpack
  import spdif_fmt_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  fmt_mode_e         mode,
  output subframe_t         fields
);
  localparam int PAD16 = AUDIO_W - 16;
  localparam int PAD20 = AUDIO_W - 20;

  always_comb begin
    fields = '0;
    unique case (mode)
      FMT_16:  fields.audio = {word[15:0], {PAD16{1'b0}}};
      FMT_20:  fields.audio = {word[19:0], {PAD20{1'b0}}};
      FMT_24:  fields.audio = word[AUDIO_W-1:0];
      FMT_RAW: begin
        fields.p     = word[31];
        fields.c     = word[30];
        fields.u     = word[29];
        fields.v     = word[28];
        fields.audio = {word[27:8], word[7:4]};
        fields.pre   = word[PRE_W-1:0];
      end
      default: fields = '0;
    endcase
  end
endmodule

// File: rtl/spdif_fmt_half.sv
module spdif_fmt_half
  import spdif_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              load,
  input  logic [HALF_W-1:0] hi_in,
  output logic              pending,
  output logic [HALF_W-1:0] hi_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      hi_q    <= '0;
    end else if (step) begin
      pending <= load;
      if (load) hi_q <= hi_in;
    end
  end
endmodule

// File: rtl/spdif_word_fmt.sv
module spdif_word_fmt
  import spdif_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [1:0]        fmt_mode,
  input  logic              pack_en,
  input  logic              sf_req,
  input  logic              err_clr,
  output logic              sf_valid,
  output logic [AUDIO_W-1:0] sf_audio,
  output logic              sf_v,
  output logic              sf_u,
  output logic              sf_c,
  output logic              sf_p,
  output logic [PRE_W-1:0]  sf_preamble,
  output logic              underrun
);
  localparam int HALF_PAD = AUDIO_W - HALF_W;

  fmt_mode_e          mode;
  subframe_t          decoded;
  subframe_t          next_sf;
  subframe_t          out_q;
  logic               packed_on;
  logic               pend;
  logic [HALF_W-1:0]  right_half;
  logic               use_right;
  logic               take;
  logic               starve;

  assign mode      = fmt_mode_e'(fmt_mode);
  assign packed_on = pack_en && (mode == FMT_16);
  assign use_right = packed_on && pend;
  assign word_ready = sf_req && !use_right;
  assign take      = word_ready && word_valid;
  assign starve    = word_ready && !word_valid;

  spdif_fmt_unpack u_unpack (
    .word   (word_data),
    .mode   (mode),
    .fields (decoded)
  );

  spdif_fmt_half u_half (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (sf_req),
    .load    (packed_on && take),
    .hi_in   (word_data[WORD_W-1:HALF_W]),
    .pending (pend),
    .hi_q    (right_half)
  );

  always_comb begin
    next_sf = '0;
    if (use_right) begin
      next_sf.audio = {right_half, {HALF_PAD{1'b0}}};
    end else if (starve) begin
      next_sf.v = 1'b1;
    end else begin
      next_sf = decoded;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q    <= '0;
      sf_valid <= 1'b0;
      underrun <= 1'b0;
    end else begin
      sf_valid <= sf_req;
      if (sf_req) out_q <= next_sf;
      underrun <= starve || (underrun && !err_clr);
    end
  end

  assign sf_audio    = out_q.audio;
  assign sf_v        = out_q.v;
  assign sf_u        = out_q.u;
  assign sf_c        = out_q.c;
  assign sf_p        = out_q.p;
  assign sf_preamble = out_q.pre;
endmodule

// File: rtl/spdif_word_fmt_chk.sv
module spdif_word_fmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sf_req,
  input logic        word_valid,
  input logic        word_ready,
  input logic        err_clr,
  input logic        sf_valid,
  input logic [23:0] sf_audio,
  input logic        sf_v,
  input logic        underrun
);
  // R7
  ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> sf_req);

  // R7
  hold_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_req |=> ($stable(sf_audio) && $stable(sf_v)));

  // R8
  strobe_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sf_req |=> sf_valid);

  // R9
  starve_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ready && !word_valid) |=> (sf_v && sf_audio == 24'h0 && underrun));

  // R10
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !err_clr) |=> underrun);
endmodule

bind spdif_word_fmt spdif_word_fmt_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sf_req     (sf_req),
  .word_valid (word_valid),
  .word_ready (word_ready),
  .err_clr    (err_clr),
  .sf_valid   (sf_valid),
  .sf_audio   (sf_audio),
  .sf_v       (sf_v),
  .underrun   (underrun)
);

// File: tb/sim_spdif_word_fmt.sv
`timescale 1ns/1ps
module sim_spdif_word_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] word_data = '0;
  logic        word_valid = 1'b0;
  logic        word_ready;
  logic [1:0]  fmt_mode = 2'b00;
  logic        pack_en = 1'b0;
  logic        sf_req = 1'b0;
  logic        err_clr = 1'b0;
  logic        sf_valid;
  logic [23:0] sf_audio;
  logic        sf_v, sf_u, sf_c, sf_p;
  logic [3:0]  sf_preamble;
  logic        underrun;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // model state
  logic [35:0] m_out = '0;
  logic        m_pend = 1'b0;
  logic [15:0] m_right = '0;
  logic        m_und = 1'b0;

  always #4 clk = ~clk;

  spdif_word_fmt u0 (
    .clk(clk), .rst_n(rst_n), .word_data(word_data), .word_valid(word_valid),
    .word_ready(word_ready), .fmt_mode(fmt_mode), .pack_en(pack_en),
    .sf_req(sf_req), .err_clr(err_clr), .sf_valid(sf_valid),
    .sf_audio(sf_audio), .sf_v(sf_v), .sf_u(sf_u), .sf_c(sf_c), .sf_p(sf_p),
    .sf_preamble(sf_preamble), .underrun(underrun)
  );

  // {audio[23:0], v, u, c, p, pre[3:0]}
  function automatic logic [35:0] ref_fields(input logic [31:0] w, input logic [1:0] m);
    logic [23:0] a;
    logic [35:0] r;
    r = '0;
    case (m)
      2'd0: begin a = (w & 32'h0000_FFFF) << 8; r = {a, 8'h00}; end
      2'd1: begin a = (w & 32'h000F_FFFF) << 4; r = {a, 8'h00}; end
      2'd2: begin a = w[23:0];                 r = {a, 8'h00}; end
      default: begin
        a = w[27:4];
        r = {a, w[28], w[29], w[30], w[31], w[3:0]};
      end
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, check ready, clock, check outputs at next negedge
  task automatic step(input logic req, input logic vld, input logic [31:0] w,
                      input logic [1:0] m, input logic pk, input logic clr);
    logic pkd, use_r, need, starve, exp_rdy, exp_valid;
    logic [35:0] nxt;
    string tag;
    sf_req = req; word_valid = vld; word_data = w; fmt_mode = m;
    pack_en = pk; err_clr = clr;
    pkd    = pk && (m == 2'd0);
    use_r  = pkd && m_pend;
    need   = !use_r;
    exp_rdy = req && need;
    starve = exp_rdy && !vld;
    #1;
    check("R7 ready", {63'd0, word_ready}, {63'd0, exp_rdy});
    if (!req) begin
      tag = "R7 hold";
      nxt = m_out;
    end else if (use_r) begin
      tag = "R5 right";
      nxt = {m_right, 8'h00, 8'h00};
      m_pend = 1'b0;
    end else if (starve) begin
      tag = "R9 underrun";
      nxt = {24'h0, 1'b1, 7'h0};
      m_pend = 1'b0;
    end else begin
      nxt = ref_fields(w, m);
      if (pkd) begin tag = "R5 left"; m_pend = 1'b1; m_right = w[31:16]; end
      else begin
        m_pend = 1'b0;
        case (m)
          2'd0: tag = pk ? "R6 pack" : "R1 16b";
          2'd1: tag = pk ? "R6 pack" : "R2 20b";
          2'd2: tag = pk ? "R6 pack" : "R3 24b";
          default: tag = "R4 raw";
        endcase
      end
    end
    m_out = nxt;
    m_und = starve || (m_und && !clr);
    exp_valid = req;
    @(posedge clk);
    @(negedge clk);
    check(tag, {28'd0, sf_audio, sf_v, sf_u, sf_c, sf_p, sf_preamble}, {28'd0, m_out});
    check("R8 strobe", {63'd0, sf_valid}, {63'd0, exp_valid});
    check("R10 sticky", {63'd0, underrun}, {63'd0, m_und});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5AD1F00D));
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset", {28'd0, sf_audio, sf_v, sf_u, sf_c, sf_p, sf_preamble, sf_valid, underrun},
          64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1..R4 directed
    step(1, 1, 32'h89AB_CDEF, 2'd0, 0, 0);
    step(1, 1, 32'h89AB_CDEF, 2'd1, 0, 0);
    step(1, 1, 32'h89AB_CDEF, 2'd2, 0, 0);
    step(1, 1, 32'hA123_45F7, 2'd3, 0, 0);
    step(1, 1, 32'h5EDC_BA98, 2'd3, 0, 0);
    // R7 valid without request: nothing taken, outputs hold
    step(0, 1, 32'h1111_2222, 2'd2, 0, 0);
    // R5 packed pair, source offering another word during right half
    step(1, 1, 32'hBEEF_1234, 2'd0, 1, 0);
    step(1, 1, 32'h7777_8888, 2'd0, 1, 0);
    step(1, 1, 32'hCAFE_0042, 2'd0, 1, 0);
    // R6 mode change mid pair drops right half
    step(1, 1, 32'h0F0F_A5A5, 2'd1, 1, 0);
    step(1, 1, 32'h1357_9BDF, 2'd0, 1, 0);
    step(1, 1, 32'h2468_ACE0, 2'd0, 0, 0);
    // R9 underrun in packed left, R10 sticky, clear, clear collision
    step(1, 0, 32'hFFFF_FFFF, 2'd0, 1, 0);
    step(0, 0, 32'h0, 2'd0, 1, 0);
    step(1, 1, 32'h0000_ABCD, 2'd2, 0, 1);
    step(1, 0, 32'h0, 2'd3, 0, 1);
    step(0, 0, 32'h0, 2'd3, 0, 1);
    // random
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 4) != 0, ($urandom % 8) != 0, $urandom,
           2'($urandom % 4), ($urandom % 2) == 1, ($urandom % 16) == 0);
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule